// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block models a single-port synchronous static RAM. A read and a write can follow each other on consecutive clock cycles with no idle cycle in between. Address, command, byte enables and chip enables are captured on the rising clock edge. Write data arrives a fixed number of edges after its address, and that delay equals the read latency. Because of this, the data bus carries a useful beat on every cycle whatever mix of reads and writes is issued. A static input selects the read timing. In flow-through timing, read data appears in the cycle right after the address edge. In pipelined timing, the data passes through one more output register and appears one cycle later.

A command can open a new access or continue the previous one. A continuation steps a two-bit beat counter, and the low two address bits of each beat come from the start address and that counter, in linear or interleaved order. A read can target a word whose delayed write has not yet reached the array. In that case it returns the newest data, merged per byte. An output-enable input gates the read drive at any time without waiting for a clock edge. High impedance is represented by the drive-enable output going low.

Top module: `zturn_sram`

## Requirements
- R1: With `flow_mode`=1, a read captured at edge k drives `dq_drive`=1 and the word on `rdata` from edge k until edge k+1.
- R2: With `flow_mode`=0, a read captured at edge k drives its word from edge k+1 until edge k+2. This is one cycle later than R1.
- R3: Write data on `wdata` is captured one edge after the write command in flow-through timing and two edges after it in pipelined timing, and lands at the command's address.
- R4: Reads and writes can alternate on every cycle with no idle cycles. A read always returns the value left by all earlier commands, including a write whose data has not yet reached the array.
- R5: With `ilv_order`=0, beat n of a burst started at address S uses low bits (S[1:0]+n) mod 4. The upper address bits stay those of S.
- R6: With `ilv_order`=1, beat n of a burst started at S uses low bits S[1:0] XOR n.
- R7: `byte_en` bit i enables byte i, which is `wdata`/`rdata` bits [9i+8:9i]. A byte whose enable is 0 keeps its previous value.
- R8: A new command is selected only when `ce_a`=1, `ce_b_n`=0 and `ce_c`=1. Any other combination is a deselect: it drives nothing in its output slot, and a delayed write that is already issued still completes.
- R9: While `oe`=0, `dq_drive` is 0 at once, without waiting for a clock edge. Raising `oe` again restores the pending read word.
- R10: After reset, `dq_drive` is 0 and the previous operation counts as a deselect.
- R11: With `burst_next`=1, the command repeats the previous operation type (read, write or deselect) at the next beat. `wr_en`, `addr` and the chip enables are ignored for that command, while `byte_en` is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_mode | input | 1 | Static: 1 selects flow-through timing, 0 selects pipelined timing |
| ilv_order | input | 1 | Static: 1 selects interleaved beat order, 0 selects linear order |
| ce_a | input | 1 | Chip enable, active high |
| ce_b_n | input | 1 | Chip enable, active low |
| ce_c | input | 1 | Chip enable, active high |
| burst_next | input | 1 | 1 continues the previous access at its next beat |
| wr_en | input | 1 | 1 writes, 0 reads (new commands only) |
| addr | input | ADDR_W | Word address of a new command |
| byte_en | input | BYTES | Per-byte write enables, sampled with every command |
| wdata | input | BYTES*BYTE_W | Delayed write data |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | BYTES*BYTE_W | Read word; zero while not driving |
| dq_drive | output | 1 | 1 while the block drives the data bus |

## Verification
The latency properties assume that `flow_mode` stays constant while commands are in flight, and that `oe` changes only between clock edges. The stimulus changes the timing mode only in the middle of a run of deselect cycles. It toggles `oe` only in the half period after a falling edge and restores it before the next rising edge. The properties also assume that each write's data is present on `wdata` at the edge its timing dictates. The bench drives that word from a queue indexed by the read latency, and drives random filler on the other cycles.

// File: rtl/zturn_pkg.sv
package zturn_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // low address bits of a burst beat
   function automatic logic [1:0] beat_ofs(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
      return ilv ? (start ^ beat) : (start + beat);
   endfunction

endpackage

// File: rtl/zturn_burst.sv
module zturn_burst
   import zturn_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ilv,
   input  logic              sel,
   input  logic              cont,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTES-1:0]  be,
   output op_e               cur_op,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [BYTES-1:0]  s1_be
);

   op_e               prev_op;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        beat_q;
   logic [ADDR_W-1:0] cur_base;
   logic [1:0]        cur_beat;
   logic [ADDR_W-1:0] cur_addr;

   always_comb begin
      if (cont) begin
         cur_op   = prev_op;
         cur_base = base_q;
         cur_beat = beat_q + 2'd1;
      end else begin
         cur_op   = !sel ? OP_NONE : (wr ? OP_WRITE : OP_READ);
         cur_base = addr;
         cur_beat = 2'd0;
      end
      cur_addr = {cur_base[ADDR_W-1:2], beat_ofs(cur_base[1:0], cur_beat, ilv)};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_op <= OP_NONE;
         base_q  <= '0;
         beat_q  <= '0;
         s1_op   <= OP_NONE;
         s1_addr <= '0;
         s1_be   <= '0;
      end else begin
         prev_op <= cur_op;
         base_q  <= cur_base;
         beat_q  <= cur_beat;
         s1_op   <= cur_op;
         s1_addr <= cur_addr;
         s1_be   <= be;
      end
   end

   AST_CONT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && s1_op == OP_NONE) |-> (cur_op == OP_NONE)); // R11

endmodule

// File: rtl/zturn_wralign.sv
module zturn_wralign
   import zturn_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flow,
   input  op_e                     s1_op,
   input  logic [ADDR_W-1:0]       s1_addr,
   input  logic [BYTES-1:0]        s1_be,
   input  logic [BYTES*BYTE_W-1:0] wdata,
   output logic                    cm_en,
   output logic [ADDR_W-1:0]       cm_addr,
   output logic [BYTES-1:0]        cm_be,
   output logic [BYTES*BYTE_W-1:0] cm_data
);

   logic              s2_wr;
   logic [ADDR_W-1:0] s2_addr;
   logic [BYTES-1:0]  s2_be;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_be   <= '0;
      end else begin
         s2_wr   <= (s1_op == OP_WRITE);
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   always_comb begin
      if (flow) begin
         cm_en   = (s1_op == OP_WRITE);
         cm_addr = s1_addr;
         cm_be   = s1_be;
      end else begin
         cm_en   = s2_wr;
         cm_addr = s2_addr;
         cm_be   = s2_be;
      end
      cm_data = wdata;
   end

endmodule

// File: rtl/zturn_array.sv
module zturn_array #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [BYTES-1:0]        wbe,
   input  logic [BYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [BYTES*BYTE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wbe[b]) cells[waddr] <= wdata[b*BYTE_W +: BYTE_W];
      end

      assign rdata[b*BYTE_W +: BYTE_W] = cells[raddr];
   end

endmodule

// File: rtl/zturn_rdpath.sv
module zturn_rdpath #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flow,
   input  logic                    oe,
   input  logic                    rd_req,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [BYTES*BYTE_W-1:0] arr_data,
   input  logic                    cm_en,
   input  logic [ADDR_W-1:0]       cm_addr,
   input  logic [BYTES-1:0]        cm_be,
   input  logic [BYTES*BYTE_W-1:0] cm_data,
   output logic [BYTES*BYTE_W-1:0] rdata,
   output logic                    dq_drive
);

   localparam int DATA_W = BYTES * BYTE_W;

   logic              hit;
   logic [DATA_W-1:0] merged;
   logic              o_valid;
   logic [DATA_W-1:0] o_data;
   logic              drive_int;
   logic [DATA_W-1:0] data_int;

   assign hit = cm_en && (cm_addr == rd_addr);

   for (genvar b = 0; b < BYTES; b++) begin : g_fwd
      assign merged[b*BYTE_W +: BYTE_W] = (hit && cm_be[b]) ?
             cm_data[b*BYTE_W +: BYTE_W] : arr_data[b*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_data  <= '0;
      end else begin
         o_valid <= rd_req;
         o_data  <= merged;
      end
   end

   assign drive_int = flow ? rd_req : o_valid;
   assign data_int  = flow ? merged : o_data;
   assign dq_drive  = oe && drive_int;
   assign rdata     = dq_drive ? data_int : '0;

   AST_QUIET_IN_RESET: assert property (@(posedge clk)
      !rst_n |=> !dq_drive); // R10

endmodule

// File: rtl/zturn_sram.sv
module zturn_sram
   import zturn_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flow_mode,
   input  logic                    ilv_order,
   input  logic                    ce_a,
   input  logic                    ce_b_n,
   input  logic                    ce_c,
   input  logic                    burst_next,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [BYTES-1:0]        byte_en,
   input  logic [BYTES*BYTE_W-1:0] wdata,
   input  logic                    oe,
   output logic [BYTES*BYTE_W-1:0] rdata,
   output logic                    dq_drive
);

   localparam int DATA_W = BYTES * BYTE_W;

   if (ADDR_W < 3) begin : g_chk_aw
      $error("zturn_sram: ADDR_W must be at least 3");
   end
   if (BYTES < 1 || BYTE_W < 1) begin : g_chk_dw
      $error("zturn_sram: BYTES and BYTE_W must be positive");
   end

   logic              sel;
   op_e               cur_op;
   op_e               s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic [BYTES-1:0]  s1_be;
   logic              cm_en;
   logic [ADDR_W-1:0] cm_addr;
   logic [BYTES-1:0]  cm_be;
   logic [DATA_W-1:0] cm_data;
   logic [DATA_W-1:0] arr_data;

   assign sel = ce_a && !ce_b_n && ce_c;

   zturn_burst #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
      .clk(clk), .rst_n(rst_n), .ilv(ilv_order), .sel(sel),
      .cont(burst_next), .wr(wr_en), .addr(addr), .be(byte_en),
      .cur_op(cur_op), .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
   );

   zturn_wralign #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_wralign (
      .clk(clk), .rst_n(rst_n), .flow(flow_mode),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be), .wdata(wdata),
      .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be), .cm_data(cm_data)
   );

   zturn_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
      .clk(clk), .we(cm_en), .waddr(cm_addr), .wbe(cm_be), .wdata(cm_data),
      .raddr(s1_addr), .rdata(arr_data)
   );

   zturn_rdpath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_rdpath (
      .clk(clk), .rst_n(rst_n), .flow(flow_mode), .oe(oe),
      .rd_req(s1_op == OP_READ), .rd_addr(s1_addr), .arr_data(arr_data),
      .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be), .cm_data(cm_data),
      .rdata(rdata), .dq_drive(dq_drive)
   );

   AST_FLOW_RD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && cur_op == OP_READ) |=> (dq_drive == oe)); // R1
   AST_PIPE_RD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && cur_op == OP_READ) |=> ##1 (dq_drive == oe)); // R2
   AST_FLOW_WR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && cur_op == OP_WRITE) |=> (cm_en && !dq_drive)); // R3
   AST_PIPE_WR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && cur_op == OP_WRITE) |=> ##1 (cm_en && !dq_drive)); // R3
   AST_FLOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && cur_op == OP_NONE) |=> !dq_drive); // R8
   AST_PIPE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && cur_op == OP_NONE) |=> ##1 !dq_drive); // R8

endmodule

// File: tb/zturn_sram_tb.sv
`timescale 1ns/1ps
module zturn_sram_tb;
   localparam int AW = 8;
   localparam int NB = 4;
   localparam int BW = 9;
   localparam int DW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flow_mode = 1'b0;
   logic          ilv_order = 1'b0;
   logic          ce_a = 1'b0, ce_b_n = 1'b1, ce_c = 1'b0;
   logic          burst_next = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NB-1:0] byte_en = '0;
   logic [DW-1:0] wdata = '0;
   logic          oe = 1'b1;
   logic [DW-1:0] rdata;
   logic          dq_drive;

   always #2 clk = ~clk;

   zturn_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .ilv_order(ilv_order),
      .ce_a(ce_a), .ce_b_n(ce_b_n), .ce_c(ce_c), .burst_next(burst_next),
      .wr_en(wr_en), .addr(addr), .byte_en(byte_en), .wdata(wdata), .oe(oe),
      .rdata(rdata), .dq_drive(dq_drive)
   );

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] ref_mem [1<<AW];
   logic          r_isrd [4];
   logic          r_iswr [4];
   logic [DW-1:0] r_exp  [4];
   logic [DW-1:0] r_wd   [4];
   string         r_tag  [4];
   int            k = 4;
   int            lat = 2;
   int            bop = 0;
   logic [AW-1:0] bbase = '0;
   logic [1:0]    bbeat = '0;
   string         cur_tag = "R10";
   bit            oe_probe = 1'b0;

   function automatic logic [1:0] ofs(input logic [1:0] s, input logic [1:0] b, input bit ilv);
      return ilv ? (s ^ b) : (s + b);
   endfunction

   function automatic logic [DW-1:0] rnd_word();
      return DW'({$urandom(), $urandom()});
   endfunction

   task automatic chk(input string tag, input bit good, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input bit cont, input bit sel, input bit wr, input logic [AW-1:0] a, input logic [NB-1:0] be);
      int s;
      int op;
      logic [AW-1:0] base;
      logic [1:0] beat;
      logic [AW-1:0] ea;
      logic [DW-1:0] d;
      logic [2:0] cep;
      @(negedge clk);
      s = (k - lat) & 3;
      if (r_isrd[s]) begin
         chk(r_tag[s], dq_drive === 1'b1 && rdata === r_exp[s], rdata, r_exp[s]);
         if (oe_probe) begin
            oe = 1'b0;
            #0.5;
            chk("R9", dq_drive === 1'b0, DW'(dq_drive), '0);
            oe = 1'b1;
            #0.5;
            chk("R9", dq_drive === 1'b1 && rdata === r_exp[s], rdata, r_exp[s]);
         end
      end else begin
         chk(r_tag[s], dq_drive === 1'b0, DW'(dq_drive), '0);
      end
      wdata = r_iswr[s] ? r_wd[s] : rnd_word();
      if (sel && !cont) cep = 3'b101;
      else begin
         cep = 3'($urandom() % 8);
         if (!cont && cep == 3'b101) cep = 3'b100;
      end
      {ce_a, ce_b_n, ce_c} = cep;
      burst_next = cont;
      wr_en   = cont ? 1'($urandom()) : wr;
      addr    = cont ? AW'($urandom()) : a;
      byte_en = be;
      if (cont) begin
         op = bop; base = bbase; beat = bbeat + 2'd1;
      end else begin
         op = !sel ? 0 : (wr ? 2 : 1); base = a; beat = 2'd0;
      end
      ea = {base[AW-1:2], ofs(base[1:0], beat, ilv_order)};
      s = k & 3;
      r_isrd[s] = (op == 1);
      r_iswr[s] = (op == 2);
      r_tag[s]  = cur_tag;
      if (op == 2) begin
         d = rnd_word();
         r_wd[s] = d;
         for (int b = 0; b < NB; b++)
            if (be[b]) ref_mem[ea][b*BW +: BW] = d[b*BW +: BW];
      end else if (op == 1) begin
         r_exp[s] = ref_mem[ea];
      end
      bop = op; bbase = base; bbeat = beat;
      k++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0);
   endtask

   task automatic set_mode(input bit fl, input bit il);
      idle(3);
      flow_mode = fl; ilv_order = il; lat = fl ? 1 : 2;
      idle(3);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20250));
      for (int i = 0; i < 4; i++) begin
         r_isrd[i] = 0; r_iswr[i] = 0; r_exp[i] = '0; r_wd[i] = '0; r_tag[i] = "R10";
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R10", dq_drive === 1'b0, DW'(dq_drive), '0);
      rst_n = 1'b1;
      // R10/R11: continue right after reset is a deselect
      cur_tag = "R10";
      step(1, 1, 0, 8'h10, '0);
      step(1, 1, 0, 8'h10, '0);
      idle(2);

      // R3: fill in pipelined timing, read some back
      cur_tag = "R3";
      for (int a = 0; a < (1<<AW); a++) step(0, 1, 1, AW'(a), '1);
      for (int a = 0; a < 16; a++) step(0, 1, 0, AW'(a*7), '0);

      for (int m = 0; m < 2; m++) begin
         set_mode(m[0], 1'b0);
         // R4/R7: back-to-back write/read on one word, partial bytes
         cur_tag = "R4";
         step(0, 1, 1, 8'h21, '1);
         step(0, 1, 0, 8'h21, '0);
         cur_tag = "R7";
         step(0, 1, 1, 8'h21, 4'b0101);
         step(0, 1, 0, 8'h21, '0);
         step(0, 1, 1, 8'h21, 4'b1000);
         step(0, 1, 0, 8'h21, '0);
         step(0, 1, 0, 8'h21, '0);
         // R8: deselects do not cancel a pending write
         cur_tag = "R8";
         step(0, 1, 1, 8'h33, '1);
         step(0, 0, 0, 8'h33, '0);
         step(0, 0, 1, 8'h33, '0);
         step(0, 1, 0, 8'h33, '0);
         for (int i = 0; i < 8; i++) step(0, 0, i[0], 8'h40, '1);
         // R11: continuation keeps op type, ignores wr/addr/enables
         cur_tag = "R11";
         step(0, 1, 1, 8'h51, '1);
         step(1, 0, 0, 8'h00, 4'b0011);
         step(1, 0, 0, 8'h00, '1);
         step(0, 1, 0, 8'h51, '0);
         step(1, 0, 1, 8'h00, '0);
         step(1, 0, 1, 8'h00, '0);
         step(1, 0, 1, 8'h00, '0);
         step(0, 0, 0, 8'h00, '0);
         step(1, 1, 0, 8'h00, '0);
         // R5: linear burst from offset 1
         set_mode(m[0], 1'b0);
         cur_tag = "R5";
         step(0, 1, 1, 8'h65, '1);
         for (int i = 0; i < 3; i++) step(1, 1, 1, '0, '1);
         step(0, 1, 0, 8'h65, '0);
         for (int i = 0; i < 3; i++) step(1, 1, 0, '0, '0);
         step(0, 1, 0, 8'h66, '0);
         step(0, 1, 0, 8'h64, '0);
         // R6: interleaved burst from offset 1
         set_mode(m[0], 1'b1);
         cur_tag = "R6";
         step(0, 1, 1, 8'h75, '1);
         for (int i = 0; i < 3; i++) step(1, 1, 1, '0, '1);
         step(0, 1, 0, 8'h75, '0);
         for (int i = 0; i < 3; i++) step(1, 1, 0, '0, '0);
         step(0, 1, 0, 8'h76, '0);
         step(0, 1, 0, 8'h74, '0);
         // R9: asynchronous output enable
         cur_tag = "R9";
         oe_probe = 1'b1;
         for (int i = 0; i < 4; i++) step(0, 1, 0, AW'(8'h80 + i), '0);
         idle(2);
         oe_probe = 1'b0;
      end

      // random mix in all four mode combinations
      for (int m = 0; m < 4; m++) begin
         set_mode(m[0], m[1]);
         cur_tag = m[0] ? "R1" : "R2";
         for (int i = 0; i < 1500; i++)
            step(($urandom() % 3) == 0, ($urandom() % 8) != 0, 1'($urandom()),
                 AW'($urandom()), NB'($urandom()));
      end
      idle(4);
      summary();
      $finish;
   end
endmodule